// File: doc/BRIEF.md
# Host Parallel Bus Adapter

This block sits between an external processor bus and an internal 16-bit word port that serves registers and shared RAM. The host presents a 15-bit word address, a byte-lane bit, an active-low chip enable and two control lines. Their meaning depends on the strobe style. In one style they are a separate read strobe and write strobe. In the other style they are a common strobe plus a read/write select. Four static configuration inputs set the host data width, the byte order for byte transfers, the strobe style and the polarity of the wait output.

Every transfer moves a whole 16-bit word. On an 8-bit host, a word travels as two byte accesses on data bits 7:0. The first byte of a write is staged, and the word is committed to the internal port only when the second byte arrives. The first byte of a read fetches and latches the full word, and the second byte is served from that latch.

Reads are prefetched. After a word fetch the adapter reads the next word ahead. A later read of exactly that address, with no write in between, is answered at once without wait. Any other read holds the host off with the wait output while the word is fetched.

Top module: `hpb_adapter`

## Requirements
- R1: In 16-bit mode (`cfg_wide`=1), the first cycle of a write strobe issues one internal write of `host_wdata[15:0]` to `host_addr`. `host_lane` and `cfg_big_end` have no effect on the stored word.
- R2: In 16-bit mode, a read returns the addressed word on `host_rdata[15:0]` once wait is released.
- R3: In 8-bit mode (`cfg_wide`=0), a word moves as two byte accesses: `host_lane`=0 is the first byte and `host_lane`=1 is the second. With `cfg_big_end`=0 the first byte is word bits 7:0. With `cfg_big_end`=1 the first byte is word bits 15:8. Bytes travel on data bits 7:0, and read data bits 15:8 are driven 0.
- R4: In 8-bit mode, a first-byte write alone leaves the stored word unchanged. The word, merged from both bytes, is written when the second-byte write starts.
- R5: In 8-bit mode, a second-byte read never asserts wait and returns the other half of the word latched by the first-byte read.
- R6: With `cfg_sep_strobe`=1, `host_stb_n` low is a read and `host_sel_n` low is a write; if both are low, the read wins. With `cfg_sep_strobe`=0, `host_stb_n` low is a strobe, and `host_sel_n`=1 selects a read while 0 selects a write. Both styles give identical data results.
- R7: `host_wait` is active high when `cfg_wait_hi`=1 and active low when `cfg_wait_hi`=0.
- R8: A read that needs a word fetch and is not sequential shows wait active in the first cycle of its strobe. Wait stays active until the word is available on `host_rdata`, which is two cycles.
- R9: A word-fetching read whose address is the previous fetched address plus one, modulo 2^15, shows no wait at any time.
- R10: Any write, including a first-byte write, between two reads makes the second read non-sequential, so it asserts wait.
- R11: `host_rdata_en` is 1 exactly while `host_ce_n` is low and a read strobe is active. Otherwise `host_rdata` is 0. An external pad drives the bus from these two signals.
- R12: After reset, wait is inactive, `host_rdata_en` is 0, no internal access is requested, and no address counts as sequential.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | 1 = 16-bit host data, 0 = 8-bit |
| cfg_big_end | input | 1 | Byte order in 8-bit mode, 1 = high byte first |
| cfg_sep_strobe | input | 1 | 1 = separate read/write strobes, 0 = common strobe plus select |
| cfg_wait_hi | input | 1 | Wait polarity, 1 = active high |
| host_ce_n | input | 1 | Chip enable, active low |
| host_sel_n | input | 1 | Write strobe (separate style) or read/write select (common style) |
| host_stb_n | input | 1 | Read strobe (separate style) or common strobe, active low |
| host_addr | input | 15 | Host word address |
| host_lane | input | 1 | Byte-lane bit, 0 = first byte |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data |
| host_rdata_en | output | 1 | Read data drive enable for the pad |
| host_wait | output | 1 | Wait to host, polarity from cfg_wait_hi |
| mem_req | output | 1 | Internal word access request |
| mem_we | output | 1 | Internal access is a write |
| mem_addr | output | 15 | Internal word address |
| mem_wdata | output | 16 | Internal write data |
| mem_rdata | input | 16 | Internal read data, valid the cycle after a read request |

## Verification
The bench aims at the prefetch bookkeeping. A write slipped between reads must force wait again; an adapter that forgot to invalidate would return a stale prefetched word with no wait. The bench also reads across the wrap from the top address to zero, which a design with a wider or saturating increment would wrongly hold off. It checks the byte order in both directions together with the staging of a lone first byte: a swapped byte merge shows up as swapped halves, and an early commit shows up as a half-overwritten word read back in 16-bit mode. Random runs mix widths, strobe styles and wait polarities between accesses, so that an inverted wait, a misdecoded select line, or a second-byte read that fetches again is caught.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

    parameter int HPB_ADDR_W = 15;
    parameter int HPB_DATA_W = 16;
    localparam int HPB_BYTE_W = HPB_DATA_W / 2;

    typedef logic [HPB_ADDR_W-1:0] haddr_t;
    typedef logic [HPB_DATA_W-1:0] hword_t;
    typedef logic [HPB_BYTE_W-1:0] hbyte_t;

    // one host access, valid for the single cycle its strobe begins
    typedef struct packed {
        logic   valid;
        logic   is_rd;
        logic   lane;
        haddr_t addr;
    } hacc_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_FETCH,
        RS_PREF,
        RS_PFWAIT
    } rd_state_e;

    function automatic hbyte_t lead_byte(input hword_t w, input logic big);
        return big ? w[HPB_DATA_W-1:HPB_BYTE_W] : w[HPB_BYTE_W-1:0];
    endfunction

    function automatic hbyte_t tail_byte(input hword_t w, input logic big);
        return big ? w[HPB_BYTE_W-1:0] : w[HPB_DATA_W-1:HPB_BYTE_W];
    endfunction

    function automatic hword_t join_bytes(input hbyte_t lead, input hbyte_t tail,
                                          input logic big);
        return big ? {lead, tail} : {tail, lead};
    endfunction

endpackage

// File: rtl/hpb_strobe_decode.sv
module hpb_strobe_decode
    import hpb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cfg_sep_strobe,
    input  logic   host_ce_n,
    input  logic   host_sel_n,
    input  logic   host_stb_n,
    input  haddr_t host_addr,
    input  logic   host_lane,
    output logic   rd_now,
    output hacc_t  acc
);

    logic sel_rd;
    logic sel_wr;
    logic busy;
    logic busy_q;

    always_comb begin
        if (cfg_sep_strobe) begin
            sel_rd = !host_ce_n && !host_stb_n;
            sel_wr = !host_ce_n && !host_sel_n && host_stb_n;
        end else begin
            sel_rd = !host_ce_n && !host_stb_n && host_sel_n;
            sel_wr = !host_ce_n && !host_stb_n && !host_sel_n;
        end
        busy = sel_rd || sel_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy;
    end

    assign rd_now    = sel_rd;
    assign acc.valid = busy && !busy_q;
    assign acc.is_rd = sel_rd;
    assign acc.lane  = host_lane;
    assign acc.addr  = host_addr;

    // R6
    one_start_chk: assert property (@(posedge clk) disable iff (rst)
        acc.valid |=> !acc.valid);

endmodule

// File: rtl/hpb_read_engine.sv
module hpb_read_engine
    import hpb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cfg_wide,
    input  hacc_t  acc,
    input  hword_t mem_rdata,
    output logic   rd_req,
    output haddr_t rd_addr,
    output logic   wait_int,
    output hword_t rd_word
);

    rd_state_e state;
    haddr_t    cur_addr;
    haddr_t    pf_addr;
    hword_t    pf_word;
    logic      pf_valid;

    logic word_rd;
    logic seq_hit;
    logic fetch;
    logic any_wr;

    always_comb begin
        word_rd  = acc.valid && acc.is_rd && (cfg_wide || !acc.lane);
        seq_hit  = word_rd && pf_valid && (acc.addr == pf_addr);
        fetch    = word_rd && !seq_hit;
        any_wr   = acc.valid && !acc.is_rd;
        wait_int = fetch || (state == RS_FETCH);
        rd_req   = 1'b0;
        rd_addr  = acc.addr;
        if (fetch) begin
            rd_req = 1'b1;
        end else if (state == RS_PREF && !any_wr) begin
            rd_req  = 1'b1;
            rd_addr = cur_addr + haddr_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RS_IDLE;
            cur_addr <= '0;
            pf_addr  <= '0;
            pf_word  <= '0;
            pf_valid <= 1'b0;
            rd_word  <= '0;
        end else if (fetch) begin
            state    <= RS_FETCH;
            cur_addr <= acc.addr;
            pf_valid <= 1'b0;
        end else if (seq_hit) begin
            state    <= RS_PREF;
            cur_addr <= acc.addr;
            rd_word  <= pf_word;
            pf_valid <= 1'b0;
        end else if (any_wr) begin
            state    <= RS_IDLE;
            pf_valid <= 1'b0;
        end else begin
            case (state)
                RS_FETCH: begin
                    rd_word <= mem_rdata;
                    state   <= RS_PREF;
                end
                RS_PREF:   state <= RS_PFWAIT;
                RS_PFWAIT: begin
                    pf_word  <= mem_rdata;
                    pf_addr  <= cur_addr + haddr_t'(1);
                    pf_valid <= 1'b1;
                    state    <= RS_IDLE;
                end
                default:   state <= RS_IDLE;
            endcase
        end
    end

    // R9
    seq_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
        seq_hit |-> !wait_int);

    // R10
    write_kills_pf_chk: assert property (@(posedge clk) disable iff (rst)
        any_wr |=> !pf_valid);

    // R8
    fetch_two_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == RS_FETCH) |=> (state == RS_PREF) && !wait_int);

endmodule

// File: rtl/hpb_byte_lane.sv
module hpb_byte_lane
    import hpb_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   cfg_wide,
    input  logic   cfg_big_end,
    input  hacc_t  acc,
    input  hword_t host_wdata,
    input  hword_t rd_word,
    output logic   wr_req,
    output haddr_t wr_addr,
    output hword_t wr_data,
    output hword_t rd_view
);

    hbyte_t stage;
    logic   rd_lane_q;
    logic   any_wr;
    logic   any_rd;

    assign any_wr = acc.valid && !acc.is_rd;
    assign any_rd = acc.valid && acc.is_rd;

    always_comb begin
        wr_addr = acc.addr;
        wr_req  = any_wr && (cfg_wide || acc.lane);
        wr_data = cfg_wide ? host_wdata
                           : join_bytes(stage, host_wdata[HPB_BYTE_W-1:0], cfg_big_end);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage     <= '0;
            rd_lane_q <= 1'b0;
        end else begin
            if (any_wr && !cfg_wide && !acc.lane) stage <= host_wdata[HPB_BYTE_W-1:0];
            if (any_rd) rd_lane_q <= acc.lane;
        end
    end

    always_comb begin
        if (cfg_wide)
            rd_view = rd_word;
        else if (rd_lane_q)
            rd_view = {{HPB_BYTE_W{1'b0}}, tail_byte(rd_word, cfg_big_end)};
        else
            rd_view = {{HPB_BYTE_W{1'b0}}, lead_byte(rd_word, cfg_big_end)};
    end

    // R4
    lead_byte_held_chk: assert property (@(posedge clk) disable iff (rst)
        (any_wr && !cfg_wide && !acc.lane) |-> !wr_req);

endmodule

// File: rtl/hpb_adapter.sv
module hpb_adapter
    import hpb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wide,
    input  logic                  cfg_big_end,
    input  logic                  cfg_sep_strobe,
    input  logic                  cfg_wait_hi,
    input  logic                  host_ce_n,
    input  logic                  host_sel_n,
    input  logic                  host_stb_n,
    input  logic [HPB_ADDR_W-1:0] host_addr,
    input  logic                  host_lane,
    input  logic [HPB_DATA_W-1:0] host_wdata,
    output logic [HPB_DATA_W-1:0] host_rdata,
    output logic                  host_rdata_en,
    output logic                  host_wait,
    output logic                  mem_req,
    output logic                  mem_we,
    output logic [HPB_ADDR_W-1:0] mem_addr,
    output logic [HPB_DATA_W-1:0] mem_wdata,
    input  logic [HPB_DATA_W-1:0] mem_rdata
);

    hacc_t  acc;
    logic   rd_now;
    logic   rd_req;
    haddr_t rd_addr;
    logic   wait_int;
    hword_t rd_word;
    logic   wr_req;
    haddr_t wr_addr;
    hword_t wr_data;
    hword_t rd_view;

    hpb_strobe_decode u_decode (
        .clk            (clk),
        .rst            (rst),
        .cfg_sep_strobe (cfg_sep_strobe),
        .host_ce_n      (host_ce_n),
        .host_sel_n     (host_sel_n),
        .host_stb_n     (host_stb_n),
        .host_addr      (host_addr),
        .host_lane      (host_lane),
        .rd_now         (rd_now),
        .acc            (acc)
    );

    hpb_read_engine u_engine (
        .clk       (clk),
        .rst       (rst),
        .cfg_wide  (cfg_wide),
        .acc       (acc),
        .mem_rdata (mem_rdata),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .wait_int  (wait_int),
        .rd_word   (rd_word)
    );

    hpb_byte_lane u_lane (
        .clk         (clk),
        .rst         (rst),
        .cfg_wide    (cfg_wide),
        .cfg_big_end (cfg_big_end),
        .acc         (acc),
        .host_wdata  (host_wdata),
        .rd_word     (rd_word),
        .wr_req      (wr_req),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_view     (rd_view)
    );

    // writes come from a strobe start and always win the internal port
    assign mem_req   = wr_req || rd_req;
    assign mem_we    = wr_req;
    assign mem_addr  = wr_req ? wr_addr : rd_addr;
    assign mem_wdata = wr_data;

    assign host_rdata_en = rd_now;
    assign host_rdata    = rd_now ? rd_view : '0;
    assign host_wait     = cfg_wait_hi ? wait_int : !wait_int;

    // R11
    rdata_en_ce_chk: assert property (@(posedge clk) disable iff (rst)
        host_rdata_en |-> !host_ce_n);

    // R1
    wide_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wide && acc.valid && !acc.is_rd) |->
            (mem_req && mem_we && mem_wdata == host_wdata && mem_addr == host_addr));

    // R5
    tail_read_no_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_wide && acc.valid && acc.is_rd && acc.lane) |-> (host_wait != cfg_wait_hi));

endmodule

// File: tb/hpb_adapter_tb.sv
module hpb_adapter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_wide, cfg_big_end, cfg_sep_strobe, cfg_wait_hi;
    logic        host_ce_n, host_sel_n, host_stb_n;
    logic [14:0] host_addr;
    logic        host_lane;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        host_rdata_en, host_wait;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    always #4 clk = ~clk;

    hpb_adapter dut_i (
        .clk(clk), .rst(rst),
        .cfg_wide(cfg_wide), .cfg_big_end(cfg_big_end),
        .cfg_sep_strobe(cfg_sep_strobe), .cfg_wait_hi(cfg_wait_hi),
        .host_ce_n(host_ce_n), .host_sel_n(host_sel_n), .host_stb_n(host_stb_n),
        .host_addr(host_addr), .host_lane(host_lane), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_en(host_rdata_en), .host_wait(host_wait),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // internal word memory, aliased on the low 8 address bits
    logic [15:0] bmem [256];
    logic [15:0] ref_mem [256];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= bmem[mem_addr[7:0]];
        end
    end

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int unsigned cyc = 0;
    logic        pf_ok;
    logic [14:0] pf_at;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual cycles %0d expected below 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lead_b(input logic [15:0] w, input logic big);
        return big ? w[15:8] : w[7:0];
    endfunction
    function automatic logic [7:0] tail_b(input logic [15:0] w, input logic big);
        return big ? w[7:0] : w[15:8];
    endfunction

    function automatic logic wait_on();
        return cfg_wait_hi ? host_wait : !host_wait;
    endfunction

    task automatic idle_bus();
        host_ce_n = 1'b1; host_sel_n = 1'b1; host_stb_n = 1'b1;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hw_write(input logic [14:0] a, input logic ln, input logic [15:0] d);
        @(negedge clk);
        host_addr = a; host_lane = ln; host_wdata = d; host_ce_n = 1'b0;
        if (cfg_sep_strobe) begin host_sel_n = 1'b0; host_stb_n = 1'b1; end
        else                begin host_sel_n = 1'b0; host_stb_n = 1'b0; end
        gap(2);
        idle_bus();
        gap(5);
    endtask

    task automatic hw_read(input logic [14:0] a, input logic ln,
                           output logic [15:0] d, output logic saw);
        @(negedge clk);
        host_addr = a; host_lane = ln; host_ce_n = 1'b0;
        host_sel_n = 1'b1; host_stb_n = 1'b0;
        #1;
        saw = wait_on();
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); #1;
            if (!wait_on()) break;
            saw = 1'b1;
        end
        d = host_rdata;
        chk(host_rdata_en === 1'b1, "R11 enable during read", 32'(host_rdata_en), 1);
        @(negedge clk);
        idle_bus();
        #1;
        chk(host_rdata_en === 1'b0 && host_rdata === 16'h0, "R11 released bus",
            {15'h0, host_rdata_en, host_rdata}, 0);
        gap(5);
    endtask

    task automatic do_write(input logic [14:0] a, input logic [15:0] d, input logic ln16);
        logic [7:0] junk;
        junk = 8'($urandom);
        if (cfg_wide) hw_write(a, ln16, d);
        else begin
            hw_write(a, 1'b0, {junk, lead_b(d, cfg_big_end)});
            hw_write(a, 1'b1, {~junk, tail_b(d, cfg_big_end)});
        end
        ref_mem[a[7:0]] = d;
        pf_ok = 1'b0;
    endtask

    task automatic do_read(input logic [14:0] a, output logic saw_out);
        logic [15:0] d;
        logic        saw;
        logic        expw;
        logic [15:0] w;
        w = ref_mem[a[7:0]];
        expw = !(pf_ok && a == pf_at);
        if (cfg_wide) begin
            hw_read(a, 1'($urandom), d, saw);
            chk(d === w, "R2 word read", 32'(d), 32'(w));
        end else begin
            hw_read(a, 1'b0, d, saw);
            chk(d === {8'h00, lead_b(w, cfg_big_end)}, "R3 first byte", 32'(d),
                32'({8'h00, lead_b(w, cfg_big_end)}));
        end
        if (expw) chk(saw === 1'b1, "R8 wait on fetch", 32'(saw), 1);
        else      chk(saw === 1'b0, "R9 no wait on sequential", 32'(saw), 0);
        saw_out = saw;
        if (!cfg_wide) begin
            hw_read(a, 1'b1, d, saw);
            chk(d === {8'h00, tail_b(w, cfg_big_end)}, "R3 second byte", 32'(d),
                32'({8'h00, tail_b(w, cfg_big_end)}));
            chk(saw === 1'b0, "R5 second byte no wait", 32'(saw), 0);
        end
        pf_ok = 1'b1;
        pf_at = a + 15'd1;
    endtask

    initial begin
        logic        s;
        logic [15:0] d;
        logic [14:0] a;
        void'($urandom(32'h5EED_1553));
        for (int i = 0; i < 256; i++) begin
            bmem[i]    = 16'(i * 16'h9E37 + 16'h1234);
            ref_mem[i] = 16'(i * 16'h9E37 + 16'h1234);
        end
        pf_ok = 1'b0; pf_at = '0;
        cfg_wide = 1'b1; cfg_big_end = 1'b0; cfg_sep_strobe = 1'b1; cfg_wait_hi = 1'b1;
        idle_bus(); host_addr = '0; host_lane = 1'b0; host_wdata = '0;
        rst = 1'b1;
        gap(4);
        rst = 1'b0;
        @(negedge clk); #1;
        // R12 reset state
        chk(host_wait === 1'b0 && host_rdata_en === 1'b0 && mem_req === 1'b0,
            "R12 reset outputs", {29'h0, host_wait, host_rdata_en, mem_req}, 0);

        // R1 wide write ignores lane and byte order
        cfg_big_end = 1'b1;
        do_write(15'h0040, 16'hA5C3, 1'b1);
        do_read(15'h0040, s);
        cfg_big_end = 1'b0;

        // R9 sequential run, then write breaks it (R10)
        do_read(15'h0100, s);
        do_read(15'h0101, s);
        do_read(15'h0102, s);
        do_write(15'h0300, 16'h0F0F, 1'b0);
        do_read(15'h0103, s);
        chk(s === 1'b1, "R10 write breaks sequence", 32'(s), 1);

        // R9 wrap from top address to zero
        do_read(15'h7FFF, s);
        do_read(15'h0000, s);
        chk(s === 1'b0, "R9 wrap is sequential", 32'(s), 0);

        // R6 common strobe style
        cfg_sep_strobe = 1'b0;
        do_write(15'h0055, 16'h3C96, 1'b0);
        do_read(15'h0055, s);
        do_read(15'h0056, s);
        chk(s === 1'b0, "R6 common style sequential read", 32'(s), 0);
        cfg_sep_strobe = 1'b1;

        // R7 active-low wait
        cfg_wait_hi = 1'b0;
        @(negedge clk); #1;
        chk(host_wait === 1'b1, "R7 idle level active low", 32'(host_wait), 1);
        do_read(15'h0222, s);
        cfg_wait_hi = 1'b1;

        // R4 lone first byte is not committed
        cfg_wide = 1'b0; cfg_big_end = 1'b0;
        hw_write(15'h0077, 1'b0, 16'hFF5A);
        pf_ok = 1'b0;
        cfg_wide = 1'b1;
        hw_read(15'h0077, 1'b0, d, s);
        chk(d === ref_mem[8'h77], "R4 first byte alone not written", 32'(d),
            32'(ref_mem[8'h77]));
        cfg_wide = 1'b0;
        hw_write(15'h0077, 1'b1, 16'h00C1);
        ref_mem[8'h77] = 16'hC15A;
        cfg_wide = 1'b1;
        hw_read(15'h0077, 1'b0, d, s);
        chk(d === 16'hC15A, "R4 merged little endian word", 32'(d), 32'hC15A);
        pf_ok = 1'b1; pf_at = 15'h0078;

        // R3 byte order both ways
        cfg_wide = 1'b0; cfg_big_end = 1'b1;
        do_write(15'h0010, 16'h1E2D, 1'b0);
        do_read(15'h0010, s);
        cfg_big_end = 1'b0;
        do_read(15'h0011, s);

        // random mix
        for (int it = 0; it < 400; it++) begin
            cfg_wide       = 1'($urandom);
            cfg_big_end    = 1'($urandom);
            cfg_sep_strobe = 1'($urandom);
            cfg_wait_hi    = 1'($urandom);
            if (pf_ok && ($urandom % 2 == 0)) a = pf_at;
            else                              a = 15'($urandom);
            if ($urandom % 3 == 0) do_write(a, 16'($urandom), 1'($urandom));
            else                   do_read(a, s);
        end

        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule